// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block turns stereo PCM sample pairs into a three-wire serial audio stream made of a bit clock, a frame clock and one data line. It supports three framings. In left-justified framing the word starts at the frame-clock edge. In I2S framing the word starts one bit later. In right-justified framing the last bit of the word sits in the final slot of the half-frame. The word length can be set from 16 to 24 bits. Slots that carry no word bit are driven low.

A producer supplies one left/right pair per frame through a valid/ready handshake. The pair is taken into the active registers when a frame starts. The framing and word length are captured at that same point. If no new pair has arrived by then, the previous pair is sent again and a sticky underrun flag is raised.

The block has two clock modes. As a slave it follows an external bit clock and frame clock, sampled on its own clock. As a master it divides its own clock, which is the master audio clock, to make both clocks. Every output comes from a flop on the system clock.

Top module: `pcm_serial_tx`

## Requirements
- R1: With `fmt_i`=0 (or 3), the word MSB is on `dout_o` at the first bit-clock rising edge after each frame-clock transition, and the remaining bits follow MSB first.
- R2: With `fmt_i`=1, the word LSB is on `dout_o` at the last bit-clock rising edge before the next frame-clock transition, and the earlier bits precede it MSB first. The slot count used is the count measured over the previous half-frame (32 in master mode).
- R3: With `fmt_i`=2, slot 0 after each frame-clock transition carries 0, and the MSB is at the second rising edge.
- R4: Samples are 24-bit and MSB-aligned. A word length W = `wlen_i` sends sample bits 23 down to 24-W. Values below 16 act as 16 and values above 24 act as 24.
- R5: Every slot of a half-frame that carries no word bit drives `dout_o` low.
- R6: In master mode, `dout_o` and the frame clock change only as the bit clock falls. With `rate_i`=0 the frame clock is clk/256 and the bit clock is clk/4. With `rate_i`=1 they are clk/128 and clk/2. Both settings give 32 slots per half-frame.
- R7: `dout_o` is 0 while `rst_ni` is low.
- R8: In slave mode the block frames its output on `bclk_i`/`lrclk_i`. `bclk_o` and `lrclk_o` are held low.
- R9: `in_ready_o` is high while the pending-pair register is empty, and a pair is accepted on valid and ready. If a frame starts with no pending pair, the previous pair is repeated and `underrun_o` is set until reset.
- R10: `fmt_i` and `wlen_i` are captured only at a frame start. A change during a frame has no effect on that frame.
- R11: Frame clock low carries the left sample and frame clock high carries the right sample, in all three framings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the master audio clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1: generate the bit and frame clocks; 0: follow the external ones |
| rate_i | input | 1 | Master divide: 0 gives /256 and /4, 1 gives /128 and /2 |
| fmt_i | input | 2 | 0 left-justified, 1 right-justified, 2 I2S, 3 left-justified |
| wlen_i | input | 5 | Word length in bits, clamped to 16..24 |
| bclk_i | input | 1 | External bit clock (slave mode) |
| lrclk_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode, else 0) |
| lrclk_o | output | 1 | Generated frame clock (master mode, else 0) |
| dout_o | output | 1 | Serial data, changed on bit-clock fall |
| in_valid_i | input | 1 | Sample pair valid |
| in_ready_o | output | 1 | Pending register can accept a pair |
| in_left_i | input | 24 | Left sample, MSB-aligned |
| in_right_i | input | 24 | Right sample, MSB-aligned |
| underrun_o | output | 1 | Sticky: a frame started with no new pair |

## Verification
Some properties are checked by assertions on every cycle. These cover the alignment of data and frame-clock changes to the generated bit-clock fall, the zero lead slot in I2S framing, and the low padding after a left-justified word. They also cover the rule that ready drops only after an accepted transfer, and that the underrun flag stays set. Other behaviour needs whole half-frames of context, so only the bench scenarios show it. This includes the bit order of complete words in each framing, the anchoring of the right-justified LSB for both a fixed and a measured slot count, the divide ratios, the repeat of a pair on underrun, and the fact that a format change in mid-frame is ignored.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic [1:0] {
    FMT_LEFT  = 2'd0,
    FMT_RIGHT = 2'd1,
    FMT_I2S   = 2'd2
  } fmt_e;
endpackage

// File: rtl/pcm_clk_unit.sv
module pcm_clk_unit #(
  parameter int DIV_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic rate_i,
  input  logic bclk_i,
  input  logic lrclk_i,
  output logic lr_o,
  output logic fall_o,
  output logic bclk_o,
  output logic lrclk_o
);
  logic [DIV_W-1:0] div_q;
  logic m_bclk, m_lr;
  logic [1:0] bsync_q, lsync_q;
  logic bclk_q, bclk_d, lr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (!master_i) div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end

  // fast rate halves both divisors, slot count per half-frame is unchanged
  assign m_bclk = rate_i ? div_q[0] : div_q[1];
  assign m_lr   = rate_i ? div_q[DIV_W-2] : div_q[DIV_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsync_q <= '0;
      lsync_q <= '0;
      bclk_q  <= 1'b0;
      bclk_d  <= 1'b0;
      lr_q    <= 1'b0;
      bclk_o  <= 1'b0;
      lrclk_o <= 1'b0;
    end else begin
      bsync_q <= {bsync_q[0], bclk_i};
      lsync_q <= {lsync_q[0], lrclk_i};
      bclk_q  <= master_i ? m_bclk : bsync_q[1];
      lr_q    <= master_i ? m_lr   : lsync_q[1];
      bclk_d  <= bclk_q;
      bclk_o  <= master_i & bclk_q;
      lrclk_o <= master_i & lr_q;
    end
  end

  assign fall_o = bclk_d & ~bclk_q;
  assign lr_o   = lr_q;

  AST_MASTER_LR_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && $past(master_i) && !$stable(lrclk_o) |-> $fell(bclk_o)); // R6
endmodule

// File: rtl/pcm_sample_hold.sv
module pcm_sample_hold #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] in_left_i,
  input  logic [SAMPLE_W-1:0] in_right_i,
  input  logic                load_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                underrun_o
);
  logic                pend_v;
  logic [SAMPLE_W-1:0] pend_l, pend_r, cur_l, cur_r;
  logic                udr_q;
  logic                take;

  assign in_ready_o = ~pend_v;
  assign take       = load_i & pend_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v <= 1'b0;
      pend_l <= '0;
      pend_r <= '0;
      cur_l  <= '0;
      cur_r  <= '0;
      udr_q  <= 1'b0;
    end else begin
      if (take) begin
        cur_l  <= pend_l;
        cur_r  <= pend_r;
        pend_v <= 1'b0;
      end else if (in_valid_i && !pend_v) begin
        pend_l <= in_left_i;
        pend_r <= in_right_i;
        pend_v <= 1'b1;
      end
      if (load_i && !pend_v) udr_q <= 1'b1;
    end
  end

  // next-active view so the first slot of a frame already sees the new pair
  assign left_o     = take ? pend_l : cur_l;
  assign right_o    = take ? pend_r : cur_r;
  assign underrun_o = udr_q;

  AST_READY_DROP_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ready_o) |-> $past(in_valid_i)); // R9
  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o); // R9
endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
  import pcm_tx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int MIN_W     = 16,
  parameter int CNT_W     = 8,
  parameter int DEF_SLOTS = 32,
  localparam int WL_W     = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fall_i,
  input  logic                lr_i,
  input  logic [1:0]          fmt_i,
  input  logic [WL_W-1:0]     wlen_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                frame_start_o,
  output logic                dout_o
);
  localparam logic [CNT_W-1:0] SLOT_CAP = {{(CNT_W-1){1'b1}}, 1'b0};

  logic              lr_prev, seen;
  logic [CNT_W-1:0]  slot_q, meas_q, slot_n, meas_n;
  logic [1:0]        fmt_q, fmt_n;
  logic [WL_W-1:0]   wl_q, wl_n, wl_c;
  logic [CNT_W-1:0]  wl_ext;
  logic              half_start;
  logic [SAMPLE_W-1:0] word, sh;
  int                pos;
  logic              bit_n;

  assign half_start    = fall_i && (lr_i != lr_prev);
  assign frame_start_o = half_start && !lr_i;

  always_comb begin
    if (wlen_i < WL_W'(MIN_W))         wl_c = WL_W'(MIN_W);
    else if (wlen_i > WL_W'(SAMPLE_W)) wl_c = WL_W'(SAMPLE_W);
    else                               wl_c = wlen_i;
  end

  always_comb begin
    slot_n = half_start ? '0 : ((slot_q < SLOT_CAP) ? slot_q + 1'b1 : slot_q);
    meas_n = (half_start && seen) ? slot_q + 1'b1 : meas_q;
    fmt_n  = frame_start_o ? fmt_i : fmt_q;
    wl_n   = frame_start_o ? wl_c : wl_q;
    wl_ext = CNT_W'(wl_n);
    word   = lr_i ? right_i : left_i;
    case (fmt_n)
      FMT_RIGHT: pos = int'(slot_n) + int'(wl_n) - int'(meas_n);
      FMT_I2S:   pos = int'(slot_n) - 1;
      default:   pos = int'(slot_n);
    endcase
    sh    = word << pos;
    bit_n = (pos >= 0) && (pos < int'(wl_n)) && sh[SAMPLE_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_prev <= 1'b0;
      seen    <= 1'b0;
      slot_q  <= '0;
      meas_q  <= CNT_W'(DEF_SLOTS);
      fmt_q   <= FMT_LEFT;
      wl_q    <= WL_W'(SAMPLE_W);
      dout_o  <= 1'b0;
    end else if (fall_i) begin
      lr_prev <= lr_i;
      if (half_start) seen <= 1'b1;
      slot_q  <= slot_n;
      meas_q  <= meas_n;
      fmt_q   <= fmt_n;
      wl_q    <= wl_n;
      dout_o  <= bit_n;
    end
  end

  AST_I2S_LEAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_start && (fmt_n == FMT_I2S) |=> !dout_o); // R3
  AST_LEFT_PAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i && (fmt_n == FMT_LEFT) && (slot_n >= wl_ext) |=> !dout_o); // R5
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx #(
  parameter int SAMPLE_W = 24,
  parameter int MIN_W    = 16,
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 8,
  localparam int WL_W    = $clog2(SAMPLE_W + 1),
  localparam int HALF_SLOTS = 1 << (DIV_W - 3)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                master_i,
  input  logic                rate_i,
  input  logic [1:0]          fmt_i,
  input  logic [WL_W-1:0]     wlen_i,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  output logic                bclk_o,
  output logic                lrclk_o,
  output logic                dout_o,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] in_left_i,
  input  logic [SAMPLE_W-1:0] in_right_i,
  output logic                underrun_o
);
  logic                lr, fall, frame_start;
  logic [SAMPLE_W-1:0] act_l, act_r;

  pcm_clk_unit #(.DIV_W(DIV_W)) u_clk (
    .clk_i, .rst_ni, .master_i, .rate_i, .bclk_i, .lrclk_i,
    .lr_o(lr), .fall_o(fall), .bclk_o, .lrclk_o
  );

  pcm_sample_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_left_i, .in_right_i,
    .load_i(frame_start), .left_o(act_l), .right_o(act_r), .underrun_o
  );

  pcm_slot_ctrl #(
    .SAMPLE_W(SAMPLE_W), .MIN_W(MIN_W), .CNT_W(CNT_W), .DEF_SLOTS(HALF_SLOTS)
  ) u_slot (
    .clk_i, .rst_ni, .fall_i(fall), .lr_i(lr), .fmt_i, .wlen_i,
    .left_i(act_l), .right_i(act_r), .frame_start_o(frame_start), .dout_o
  );

  AST_DOUT_ON_BCLK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && $past(master_i) && !$stable(dout_o) |-> $fell(bclk_o)); // R6
endmodule

// File: tb/pcm_serial_tx_bench.sv
`timescale 1ns/1ps
module pcm_serial_tx_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master_i = 1'b1, rate_i = 1'b0;
  logic [1:0] fmt_i = 2'd0;
  logic [4:0] wlen_i = 5'd24;
  logic bclk_i = 1'b1, lrclk_i = 1'b0;
  logic bclk_o, lrclk_o, dout_o, in_ready_o, underrun_o;
  logic in_valid_i = 1'b0;
  logic [23:0] in_left_i = '0, in_right_i = '0;

  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  pcm_serial_tx u_pcm_serial_tx (
    .clk_i(clk), .rst_ni, .master_i, .rate_i, .fmt_i, .wlen_i,
    .bclk_i, .lrclk_i, .bclk_o, .lrclk_o, .dout_o,
    .in_valid_i, .in_ready_o, .in_left_i, .in_right_i, .underrun_o
  );

  // receiver model: capture one half-frame per frame-clock level
  logic eb_prev = 1'b0, el_prev = 1'b0;
  logic [63:0] hb = '0, done_bits = '0;
  int hn = 0, done_n = 0, done_cnt = 0;
  logic done_lr = 1'b0;

  always @(negedge clk) begin
    logic eb, el;
    eb = master_i ? bclk_o : bclk_i;
    el = master_i ? lrclk_o : lrclk_i;
    if (eb && !eb_prev) begin
      if (el != el_prev) begin
        done_bits = hb; done_n = hn; done_lr = el_prev; done_cnt++;
        hb = '0; hn = 0;
      end
      if (hn < 64) hb[hn] = dout_o;
      hn++;
      el_prev = el;
    end
    eb_prev = eb;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_half(int fmt, int w, int n, logic [23:0] word);
    logic [63:0] e = '0;
    for (int s = 0; s < n; s++) begin
      int p;
      if (fmt == 1)      p = s - (n - w);
      else if (fmt == 2) p = s - 1;
      else               p = s;
      if (p >= 0 && p < w) e[s] = word[23-p];
    end
    return e;
  endfunction

  task automatic push(logic [23:0] l, logic [23:0] r);
    while (!in_ready_o) @(negedge clk);
    in_valid_i = 1'b1; in_left_i = l; in_right_i = r;
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic wait_half(logic lr);
    int c;
    forever begin
      c = done_cnt;
      while (done_cnt == c) @(negedge clk);
      if (done_lr == lr) break;
    end
  endtask

  task automatic check_frame(string req, int fmt, int w, int n, logic [23:0] l, logic [23:0] r);
    logic [63:0] m;
    m = (n >= 64) ? '1 : ((64'd1 << n) - 1);
    wait_half(1'b0);
    chk({req, " left"}, (done_bits & m) | (64'(done_n) << 56), exp_half(fmt, w, n, l) | (64'(n) << 56));
    wait_half(1'b1);
    chk({req, " right"}, (done_bits & m) | (64'(done_n) << 56), exp_half(fmt, w, n, r) | (64'(n) << 56));
  endtask

  task automatic run_case(string req, logic [1:0] f, logic [4:0] wl, int efmt, int ew, int n,
                          logic [23:0] l, logic [23:0] r);
    fmt_i = f; wlen_i = wl;
    push(l, r);
    push(l, r);
    check_frame(req, efmt, ew, n, l, r);
  endtask

  function automatic logic sig(bit use_lr);
    return use_lr ? lrclk_o : bclk_o;
  endfunction

  task automatic measure(string req, bit use_lr, int expv);
    int t = 0;
    logic pv;
    for (int k = 0; k < 2; k++) begin
      pv = sig(use_lr);
      forever begin @(negedge clk); if (sig(use_lr) && !pv) break; pv = sig(use_lr); end
    end
    pv = sig(use_lr);
    forever begin @(negedge clk); t++; if (sig(use_lr) && !pv) break; pv = sig(use_lr); end
    chk(req, 64'(t), 64'(expv));
  endtask

  task automatic drive_slave(int halves, int n);
    for (int h = 0; h < halves; h++) begin
      for (int s = 0; s < n; s++) begin
        @(posedge clk);
        if (s == 0) lrclk_i <= (h % 2 == 0);
        bclk_i <= 1'b0;
        repeat (6) @(posedge clk);
        bclk_i <= 1'b1;
        repeat (5) @(posedge clk);
      end
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 dout in reset", 64'(dout_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9 ready after reset", 64'(in_ready_o), 64'd1);
    chk("R9 underrun after reset", 64'(underrun_o), 64'd0);
  endtask

  task automatic t_left_24;
    run_case("R1 R11 left-justified 24b", 2'd0, 5'd24, 0, 24, 32, 24'hA5C3F1, 24'h1E7B2D);
    chk("R9 no underrun while fed", 64'(underrun_o), 64'd0);
  endtask

  task automatic t_left_16;
    run_case("R4 R5 left-justified 16b", 2'd0, 5'd16, 0, 16, 32, 24'hF00F0F, 24'h800001);
  endtask

  task automatic t_right_20;
    run_case("R2 right-justified 20b", 2'd1, 5'd20, 1, 20, 32, 24'hC3A5FF, 24'h5A0F81);
  endtask

  task automatic t_i2s_24;
    run_case("R3 i2s 24b", 2'd2, 5'd24, 2, 24, 32, 24'hFFFFFF, 24'h9BCDE7);
  endtask

  task automatic t_clamp;
    run_case("R4 word length clamp", 2'd3, 5'd30, 0, 24, 32, 24'h3C9A55, 24'hE1D2C3);
  endtask

  task automatic t_mid_change;
    fmt_i = 2'd0; wlen_i = 5'd24;
    push(24'h7A8B9C, 24'h0F1E2D);
    push(24'h7A8B9C, 24'h0F1E2D);
    fmt_i = 2'd1; wlen_i = 5'd16;
    check_frame("R10 mid-frame format change", 0, 24, 32, 24'h7A8B9C, 24'h0F1E2D);
  endtask

  task automatic t_underrun;
    run_case("R9 fed frame", 2'd0, 5'd24, 0, 24, 32, 24'h123456, 24'hFEDCBA);
    wait_half(1'b0);
    wait_half(1'b1);
    check_frame("R9 repeated pair", 0, 24, 32, 24'h123456, 24'hFEDCBA);
    chk("R9 underrun flag", 64'(underrun_o), 64'd1);
  endtask

  task automatic t_rates;
    rate_i = 1'b1;
    repeat (700) @(negedge clk);
    measure("R6 fast frame period", 1'b1, 128);
    measure("R6 fast bit period", 1'b0, 2);
    run_case("R6 R1 fast rate data", 2'd0, 5'd24, 0, 24, 32, 24'h6D2B99, 24'hB4C1E0);
    rate_i = 1'b0;
    repeat (1200) @(negedge clk);
    measure("R6 default frame period", 1'b1, 256);
    measure("R6 default bit period", 1'b0, 4);
  endtask

  task automatic t_slave;
    rst_ni = 1'b0;
    master_i = 1'b0;
    bclk_i = 1'b1; lrclk_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 dout in reset after traffic", 64'(dout_o), 64'd0);
    rst_ni = 1'b1;
    fork
      drive_slave(12, 28);
    join_none
    fmt_i = 2'd1; wlen_i = 5'd24;
    push(24'hD5AA3C, 24'h2468AC);
    push(24'hD5AA3C, 24'h2468AC);
    check_frame("R8 R2 slave right-justified 28 slots", 1, 24, 28, 24'hD5AA3C, 24'h2468AC);
    chk("R8 bclk_o low in slave", 64'(bclk_o), 64'd0);
    chk("R8 lrclk_o low in slave", 64'(lrclk_o), 64'd0);
  endtask

  initial begin
    t_reset();
    t_left_24();
    t_left_16();
    t_right_20();
    t_i2s_24();
    t_clamp();
    t_mid_change();
    t_underrun();
    t_rates();
    t_slave();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule